// File: doc/BRIEF.md
# Serial Normalized Min-Sum Check Core

This block performs the check-node update of a layered low-density parity-check decoder under the normalized min-sum rule. Variable-to-check messages enter one per accepted cycle as two's complement words. A start strobe marks the first message of a check, and a valid strobe qualifies each word. Each word is split into a sign and a magnitude, and the magnitude is clipped to the 4-bit range. A serial sorter keeps the smallest magnitude, the second smallest and the position of the smallest. A running XOR collects the sign parity, and a small sign store keeps each input sign for later use.

On the cycle after the last of the `DC` inputs is accepted, the block presents a compressed record. The record holds the scaled minimum, the scaled second minimum, the index of the minimum, the input sign vector and the check parity. The parity can feed an early-termination syndrome. At the same time the block starts to stream `DC` new check-to-variable messages, one per cycle, as 5-bit two's complement. Inputs for the next check may arrive while the previous result is still streaming, so groups can run back to back without stalls.

Top module: `minsum_check_core`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `rec_valid` are low until a complete group has been accepted.
- R2: Each input is read as signed. Its magnitude is its absolute value, saturated to 15, and this includes the most negative input code. Its sign is 1 when the input is negative.
- R3: Over one group, the block finds the smallest magnitude, the second smallest and the position (0 to DC-1, in arrival order) of the smallest. A later input equal to the current minimum replaces only the second minimum, so the earliest position of the minimum is kept.
- R4: Scaling applies m - (m >> 2) with truncation to both the minimum and the second minimum. The record reports the scaled values, and `rec_submin` is never below `rec_min`.
- R5: The output magnitude at position k is the scaled second minimum when k equals the minimum's index, and the scaled minimum otherwise.
- R6: The output sign at position k is the check parity XOR the sign of input k. `out_msg` is the 5-bit two's complement of that signed magnitude.
- R7: Bit k of `rec_signs` is the sign of input k. `rec_parity` is the XOR of all input signs, which equals the XOR of `rec_signs`.
- R8: The record (`rec_valid`, one cycle) and output position 0 appear in the cycle after the last input of a group is accepted. Positions 1 to DC-1 follow on consecutive cycles.
- R9: A valid word with no start strobe and no open group is ignored. A start strobe in the middle of a group discards that group and opens a new one. Cycles with valid low pause a group without affecting it.
- R10: A new group may be accepted while the previous result is streaming. Back-to-back groups give an unbroken output stream with the correct values for each group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_start | input | 1 | Marks the first word of a group |
| in_msg | input | IN_W | Variable-to-check message, two's complement |
| out_valid | output | 1 | Output message valid |
| out_pos | output | IDX_W | Position of the current output within its group |
| out_msg | output | MAG_W+1 | Check-to-variable message, two's complement |
| rec_valid | output | 1 | Compressed record valid, one cycle per group |
| rec_min | output | MAG_W | Scaled minimum magnitude |
| rec_submin | output | MAG_W | Scaled second-minimum magnitude |
| rec_idx | output | IDX_W | Position of the minimum |
| rec_signs | output | DC | Input sign vector, bit k for input k |
| rec_parity | output | 1 | XOR of all input signs (syndrome bit) |

## Verification
The last input of a group is taken at a rising edge. After that same edge the record and output position 0 are already present, and output position k follows k cycles later. The bench drives inputs on falling edges. It records the expected record and the expected per-position messages in FIFO order when each group is sent. A falling-edge monitor compares every `rec_valid` and `out_valid` cycle against the head of these queues, so overlapped and gapped groups are checked without cycle counting in the driver. Any output that appears when nothing is expected is counted as a miscompare.

// File: rtl/msc_pkg.sv
package msc_pkg;

  // absolute value of a signed sample, clipped to lim
  function automatic int unsigned sat_mag(input int signed v, input int unsigned lim);
    int unsigned a;
    a = (v < 0) ? unsigned'(-v) : unsigned'(v);
    return (a > lim) ? lim : a;
  endfunction

  // normalization by 0.75 as m - m/4, truncated
  function automatic int unsigned scale_mag(input int unsigned m);
    return m - (m >> 2);
  endfunction

  // sign-magnitude to signed integer
  function automatic int signed apply_sign(input logic s, input int unsigned m);
    return s ? -int'(m) : int'(m);
  endfunction

endpackage

// File: rtl/msc_sort.sv
module msc_sort #(
  parameter int IN_W  = 6,
  parameter int MAG_W = 4,
  parameter int DC    = 8,
  parameter int IDX_W = $clog2(DC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [IN_W-1:0]  in_msg,
  output logic             take,
  output logic             done,
  output logic [MAG_W-1:0] fin_min,
  output logic [MAG_W-1:0] fin_sub,
  output logic [IDX_W-1:0] fin_idx,
  output logic             fin_par,
  output logic [DC-1:0]    fin_sgn
);
  localparam int unsigned MAG_LIM = (1 << MAG_W) - 1;

  logic             active_r;
  logic [IDX_W-1:0] cnt_r;
  logic [MAG_W-1:0] min_r, sub_r;
  logic [IDX_W-1:0] idx_r;
  logic             par_r;
  logic [DC-1:0]    sgn_r;

  logic             cur_sign;
  logic [MAG_W-1:0] cur_mag;
  logic [IDX_W-1:0] pos;
  logic [MAG_W-1:0] b_min, b_sub;
  logic [IDX_W-1:0] b_idx;
  logic             b_par;
  logic [DC-1:0]    b_sgn;

  always_comb begin
    take     = in_valid && (in_start || active_r);
    cur_sign = in_msg[IN_W-1];
    cur_mag  = MAG_W'(msc_pkg::sat_mag(int'($signed(in_msg)), MAG_LIM));
    pos      = in_start ? '0 : cnt_r;
    // a new group starts from an empty sorter
    b_min = in_start ? MAG_W'(MAG_LIM) : min_r;
    b_sub = in_start ? MAG_W'(MAG_LIM) : sub_r;
    b_idx = in_start ? '0 : idx_r;
    b_par = in_start ? 1'b0 : par_r;
    b_sgn = in_start ? '0 : sgn_r;
    fin_min = b_min;
    fin_sub = b_sub;
    fin_idx = b_idx;
    if (cur_mag < b_min) begin
      fin_sub = b_min;
      fin_min = cur_mag;
      fin_idx = pos;
    end else if (cur_mag < b_sub) begin
      fin_sub = cur_mag;   // ties with the minimum land here
    end
    fin_par      = b_par ^ cur_sign;
    fin_sgn      = b_sgn;
    fin_sgn[pos] = cur_sign;
    done = take && (pos == IDX_W'(DC - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_r <= 1'b0;
      cnt_r    <= '0;
      min_r    <= '0;
      sub_r    <= '0;
      idx_r    <= '0;
      par_r    <= 1'b0;
      sgn_r    <= '0;
    end else if (take) begin
      active_r <= !done;
      cnt_r    <= pos + IDX_W'(1);
      min_r    <= fin_min;
      sub_r    <= fin_sub;
      idx_r    <= fin_idx;
      par_r    <= fin_par;
      sgn_r    <= fin_sgn;
    end
  end

endmodule

// File: rtl/msc_stream.sv
module msc_stream #(
  parameter int MAG_W = 4,
  parameter int DC    = 8,
  parameter int IDX_W = $clog2(DC),
  parameter int OUT_W = MAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAG_W-1:0] ld_min,
  input  logic [MAG_W-1:0] ld_sub,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic             ld_par,
  input  logic [DC-1:0]    ld_sgn,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_pos,
  output logic [OUT_W-1:0] out_msg,
  output logic             rec_valid,
  output logic [MAG_W-1:0] rec_min,
  output logic [MAG_W-1:0] rec_submin,
  output logic [IDX_W-1:0] rec_idx,
  output logic [DC-1:0]    rec_signs,
  output logic             rec_parity
);
  logic             busy_r, recv_r, par_r;
  logic [IDX_W-1:0] pos_r, idx_r;
  logic [MAG_W-1:0] min_r, sub_r;
  logic [DC-1:0]    sgn_r;
  logic [MAG_W-1:0] sel_mag;
  logic             sel_sign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      recv_r <= 1'b0;
      pos_r  <= '0;
      min_r  <= '0;
      sub_r  <= '0;
      idx_r  <= '0;
      par_r  <= 1'b0;
      sgn_r  <= '0;
    end else begin
      recv_r <= load;
      if (load) begin
        busy_r <= 1'b1;
        pos_r  <= '0;
        min_r  <= MAG_W'(msc_pkg::scale_mag(int'(ld_min)));
        sub_r  <= MAG_W'(msc_pkg::scale_mag(int'(ld_sub)));
        idx_r  <= ld_idx;
        par_r  <= ld_par;
        sgn_r  <= ld_sgn;
      end else if (busy_r) begin
        if (pos_r == IDX_W'(DC - 1)) busy_r <= 1'b0;
        else                         pos_r  <= pos_r + IDX_W'(1);
      end
    end
  end

  always_comb begin
    sel_mag  = (pos_r == idx_r) ? sub_r : min_r;
    sel_sign = par_r ^ sgn_r[pos_r];
    out_msg  = OUT_W'(msc_pkg::apply_sign(sel_sign, int'(sel_mag)));
  end

  assign out_valid  = busy_r;
  assign out_pos    = pos_r;
  assign rec_valid  = recv_r;
  assign rec_min    = min_r;
  assign rec_submin = sub_r;
  assign rec_idx    = idx_r;
  assign rec_signs  = sgn_r;
  assign rec_parity = par_r;

endmodule

// File: rtl/minsum_check_core.sv
module minsum_check_core #(
  parameter int IN_W  = 6,
  parameter int MAG_W = 4,
  parameter int DC    = 8,
  parameter int IDX_W = $clog2(DC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [IN_W-1:0]  in_msg,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_pos,
  output logic [MAG_W:0]   out_msg,
  output logic             rec_valid,
  output logic [MAG_W-1:0] rec_min,
  output logic [MAG_W-1:0] rec_submin,
  output logic [IDX_W-1:0] rec_idx,
  output logic [DC-1:0]    rec_signs,
  output logic             rec_parity
);
  logic             grp_take, grp_done;
  logic [MAG_W-1:0] grp_min, grp_sub;
  logic [IDX_W-1:0] grp_idx;
  logic             grp_par;
  logic [DC-1:0]    grp_sgn;

  msc_sort #(.IN_W(IN_W), .MAG_W(MAG_W), .DC(DC), .IDX_W(IDX_W)) u_sort (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_msg(in_msg), .take(grp_take), .done(grp_done),
    .fin_min(grp_min), .fin_sub(grp_sub), .fin_idx(grp_idx),
    .fin_par(grp_par), .fin_sgn(grp_sgn)
  );

  msc_stream #(.MAG_W(MAG_W), .DC(DC), .IDX_W(IDX_W), .OUT_W(MAG_W + 1)) u_stream (
    .clk(clk), .rst_n(rst_n), .load(grp_done),
    .ld_min(grp_min), .ld_sub(grp_sub), .ld_idx(grp_idx),
    .ld_par(grp_par), .ld_sgn(grp_sgn),
    .out_valid(out_valid), .out_pos(out_pos), .out_msg(out_msg),
    .rec_valid(rec_valid), .rec_min(rec_min), .rec_submin(rec_submin),
    .rec_idx(rec_idx), .rec_signs(rec_signs), .rec_parity(rec_parity)
  );

endmodule

// File: rtl/minsum_check_core_chk.sv
module minsum_check_core_chk #(
  parameter int MAG_W = 4,
  parameter int DC    = 8,
  parameter int IDX_W = $clog2(DC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_pos,
  input logic [MAG_W:0]   out_msg,
  input logic             rec_valid,
  input logic [MAG_W-1:0] rec_min,
  input logic [MAG_W-1:0] rec_submin,
  input logic [DC-1:0]    rec_signs,
  input logic             rec_parity
);
  localparam int LIM = (1 << MAG_W) - 1;
  localparam int CAP = LIM - (LIM >> 2);

  logic [MAG_W:0] out_abs;
  assign out_abs = out_msg[MAG_W] ? (~out_msg + 1'b1) : out_msg;

  assert_record_with_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (out_valid && out_pos == '0));

  assert_record_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  assert_pos_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pos != IDX_W'(DC - 1)) |=>
      (out_valid && out_pos == IDX_W'($past(out_pos) + IDX_W'(1))));

  assert_sub_not_below_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_submin >= rec_min));

  assert_mag_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_abs <= (MAG_W + 1)'(CAP)));

  assert_parity_matches_signs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_parity == ^rec_signs));

endmodule

bind minsum_check_core minsum_check_core_chk #(.MAG_W(MAG_W), .DC(DC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_pos(out_pos),
  .out_msg(out_msg), .rec_valid(rec_valid), .rec_min(rec_min),
  .rec_submin(rec_submin), .rec_signs(rec_signs), .rec_parity(rec_parity)
);

// File: tb/minsum_check_core_tb.sv
module minsum_check_core_tb;
  localparam int IN_W  = 6;
  localparam int MAG_W = 4;
  localparam int DC    = 8;
  localparam int IDX_W = $clog2(DC);
  localparam int OMASK = (1 << (MAG_W + 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0;
  logic [IN_W-1:0] in_msg = '0;
  logic out_valid, rec_valid, rec_parity;
  logic [IDX_W-1:0] out_pos, rec_idx;
  logic [MAG_W:0] out_msg;
  logic [MAG_W-1:0] rec_min, rec_submin;
  logic [DC-1:0] rec_signs;

  always #4 clk = ~clk;   // 125 MHz

  minsum_check_core #(.IN_W(IN_W), .MAG_W(MAG_W), .DC(DC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_msg(in_msg), .out_valid(out_valid), .out_pos(out_pos), .out_msg(out_msg),
    .rec_valid(rec_valid), .rec_min(rec_min), .rec_submin(rec_submin),
    .rec_idx(rec_idx), .rec_signs(rec_signs), .rec_parity(rec_parity)
  );

  int vec_cnt = 0, err_cnt = 0;
  int gv[DC];
  int exp_out[$];   // (pos << 8) | msg
  int exp_rec[$];   // min | sub<<4 | idx<<8 | par<<12 | signs<<16
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  endtask

  // reference model of one group (R2..R7)
  task automatic push_expect();
    int mag[DC];
    int sg[DC];
    int mn, sb, ix, par, sv, sm, ss, m;
    par = 0; sv = 0;
    for (int i = 0; i < DC; i++) begin
      m = (gv[i] < 0) ? -gv[i] : gv[i];
      mag[i] = (m > 15) ? 15 : m;
      sg[i]  = (gv[i] < 0) ? 1 : 0;
      par ^= sg[i];
      sv |= sg[i] << i;
    end
    mn = 99; ix = 0;
    for (int i = 0; i < DC; i++) if (mag[i] < mn) begin mn = mag[i]; ix = i; end
    sb = 99;
    for (int i = 0; i < DC; i++) if (i != ix && mag[i] < sb) sb = mag[i];
    sm = mn - mn / 4;
    ss = sb - sb / 4;
    exp_rec.push_back(sm | (ss << 4) | (ix << 8) | (par << 12) | (sv << 16));
    for (int i = 0; i < DC; i++) begin
      m = (i == ix) ? ss : sm;
      m = ((par ^ sg[i]) != 0) ? -m : m;
      exp_out.push_back((i << 8) | (m & OMASK));
    end
  endtask

  task automatic send_group(input bit gaps);
    push_expect();
    for (int i = 0; i < DC; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk); in_valid = 1'b0; in_start = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1; in_start = (i == 0); in_msg = IN_W'(gv[i]);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 1'b0; in_start = 1'b0;
    end
  endtask

  // monitor: result due one edge after the last input, then one position per cycle
  always @(negedge clk) begin
    int e, act;
    if (rst_n && !done_flag) begin
      if (rec_valid) begin
        act = int'(rec_min) | (int'(rec_submin) << 4) | (int'(rec_idx) << 8) |
              (int'(rec_parity) << 12) | (int'(rec_signs) << 16);
        if (exp_rec.size() == 0) check(0, "R9 unexpected record", act, 0);
        else begin
          e = exp_rec.pop_front();
          check(act == e, "R3/R4/R7 record", act, e);
        end
      end
      if (out_valid) begin
        act = (int'(out_pos) << 8) | int'(out_msg);
        if (exp_out.size() == 0) check(0, "R9 unexpected output", act, 0);
        else begin
          e = exp_out.pop_front();
          check(act == e, "R5/R6/R8 output", act, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int lf;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && !rec_valid, "R1 in reset", {out_valid, rec_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid && !rec_valid, "R1 after reset", {out_valid, rec_valid}, 0);

    // R9: stray valid with no open group is ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b1; in_start = 1'b0; in_msg = IN_W'(i + 3);
    end
    idle(12);
    check(exp_out.size() == 0, "R9 stray words gave nothing", exp_out.size(), 0);

    // R2/R3/R5/R6/R10: sweep each code at each position, groups back to back
    for (int v = -32; v < 32; v++) begin
      for (int p = 0; p < DC; p++) begin
        for (int j = 0; j < DC; j++) gv[j] = (j == p) ? v : ((j * 7 + v + 64) % 23) - 11;
        send_group(p % 3 == 0);
      end
    end
    idle(DC + 2);

    // R3: ties, all inputs equal
    for (int v = -17; v <= 17; v++) begin
      for (int j = 0; j < DC; j++) gv[j] = v;
      send_group(0);
    end
    // R3: tie of minimum at later positions
    for (int p = 1; p < DC; p++) begin
      for (int j = 0; j < DC; j++) gv[j] = (j == 0 || j == p) ? -2 : 9 - j;
      send_group(1);
    end
    idle(DC + 2);

    // R9: start in mid-group restarts; only the second group yields output
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_start = (i == 0); in_msg = IN_W'(-1);
    end
    for (int j = 0; j < DC; j++) gv[j] = 5 - 2 * j;
    send_group(0);
    idle(DC + 2);

    // pseudo-random groups, mixed gaps and overlap (R10)
    lf = 32'h1ace;
    for (int g = 0; g < 150; g++) begin
      for (int j = 0; j < DC; j++) begin
        lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
        gv[j] = (lf % 64) - 32;
      end
      send_group(g % 4 == 0);
      if (g % 7 == 0) idle(3);
    end
    idle(DC + 4);

    check(exp_out.size() == 0 && exp_rec.size() == 0, "R8 all results delivered",
          exp_out.size() + exp_rec.size(), 0);
    finish_run();
  end

endmodule